// File: doc/BRIEF.md
# Shared Transmit Buffer Allocator

This block keeps the books for a transmit buffer pool that is shared by up to 32 channels. The pool has a fixed number of units. Each channel holds a share of the pool, and that share starts at zero after reset. A reconfiguration request names a channel, a new size and a flag that says whether the size is meant to be applied. When the size is to be applied, the block first returns the channel's present share to the pool. It then tries to reserve the new size from whatever is free. If the reservation succeeds, the channel gets its new share. If it fails, the block raises a failure interrupt and the channel is left with nothing.

Each request runs through a fixed sequence: release, check, then commit or fail. While the sequence runs, `busy_o` is held high and new requests are ignored. Completion is marked by a one-cycle `done_o` pulse, with `ok_o` giving the result. The block outputs every channel's current share and the number of free units. It does not hold the buffer memory, and it does not map addresses or move data.

Top module: `tx_pool_alloc`

## Requirements
- R1: After reset, every channel's share is 0, `free_cnt_o` equals `POOL_UNITS`, and `busy_o`, `done_o`, `ok_o` and `arf_irq_o` are all low.
- R2: A request is accepted on a rising edge where `req_valid_i` is high and `busy_o` is low. Three rising edges later, `done_o` is high for exactly one cycle. If the request carries `req_size_valid_i`=1, `req_abort_i`=0 and a size that fits, then from that cycle the channel's share equals the requested size and `ok_o`=1.
- R3: The channel's present share is returned to the pool before the new size is checked. A request therefore succeeds when the requested size is no larger than the free count plus that channel's own present share.
- R4: When the requested size is larger than the units available after the release, the request fails. `done_o`=1 and `ok_o`=0, `arf_irq_o` pulses in the same cycle, and the channel's share becomes 0.
- R5: At all times, `free_cnt_o` equals `POOL_UNITS` minus the sum of all channel shares.
- R6: With `req_size_valid_i`=0, `req_size_i` is ignored. The request then completes with `ok_o`=1 and leaves all shares and the free count unchanged.
- R7: With `req_abort_i`=1, the request completes with `ok_o`=1 and leaves all shares and the free count unchanged, whatever the values of `req_size_valid_i` and `req_size_i`.
- R8: A channel number of `NUM_CH` or above is a failure. It gives `ok_o`=0 and an `arf_irq_o` pulse, and it leaves all shares and the free count unchanged.
- R9: `busy_o` is high from the cycle after acceptance until `done_o` rises. A request presented while `busy_o` is high has no effect.
- R10: A resize to size 0 with `req_size_valid_i`=1 succeeds and returns the channel's whole share to the pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, taken only while not busy |
| req_ch_i | input | CH_IN_W (6) | Channel number; values of NUM_CH and above are invalid |
| req_size_valid_i | input | 1 | New size is to be applied |
| req_size_i | input | SIZE_W (7) | Requested share in pool units |
| req_abort_i | input | 1 | Transmit abort command; the share is not touched |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Result qualifier for done_o: 1 = success |
| arf_irq_o | output | 1 | Action-request-failure interrupt pulse |
| free_cnt_o | output | CNT_W (7) | Unallocated pool units |
| alloc_flat_o | output | NUM_CH*SIZE_W | Share of channel c at bits [c*SIZE_W +: SIZE_W] |

## Verification
Two events can fall in the same cycle: the completion pulse of one request, and the acceptance of the next one. The bench provokes this on every request by raising `req_valid_i` in the very cycle where `done_o` of the previous request is high. It then checks that the new request still completes three edges later, and that its result matches a model in which the previous commit had already taken effect. Each request also carries a stray strobe in the middle of its busy window. The bench confirms through the share and free-count outputs that this strobe changed nothing.

// File: rtl/tpa_pkg.sv
package tpa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RELEASE,
    ST_CHECK,
    ST_COMMIT,
    ST_FAIL
  } tpa_state_e;
endpackage

// File: rtl/tpa_ledger.sv
module tpa_ledger #(
  parameter int NUM_CH     = 32,
  parameter int POOL_UNITS = 64,
  parameter int SIZE_W     = 7,
  parameter int CNT_W      = 7,
  parameter int IDX_W      = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [IDX_W-1:0]         ch_i,
  input  logic [SIZE_W-1:0]        size_i,
  input  logic                     release_i,
  input  logic                     commit_i,
  output logic [CNT_W-1:0]         free_o,
  output logic [NUM_CH*SIZE_W-1:0] alloc_flat_o
);
  localparam int CMP_W = (SIZE_W > CNT_W) ? SIZE_W : CNT_W;

  logic [SIZE_W-1:0] alloc_q [NUM_CH];
  logic [CNT_W-1:0]  free_q;
  logic [SIZE_W-1:0] cur_share;

  assign cur_share = alloc_q[ch_i];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_share
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                alloc_q[g] <= '0;
      else if (release_i && ch_i == IDX_W'(g))    alloc_q[g] <= '0;
      else if (commit_i && ch_i == IDX_W'(g))     alloc_q[g] <= size_i;
    end
    assign alloc_flat_o[g*SIZE_W +: SIZE_W] = alloc_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        free_q <= CNT_W'(POOL_UNITS);
    else if (release_i) free_q <= free_q + CNT_W'(cur_share);
    else if (commit_i)  free_q <= free_q - CNT_W'(size_i);
  end

  assign free_o = free_q;

  int share_sum;
  always_comb begin
    share_sum = 0;
    for (int i = 0; i < NUM_CH; i++) share_sum += int'(alloc_q[i]);
  end

  a_r5_free_balance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(free_q) == POOL_UNITS - share_sum);

  a_r2_commit_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> CMP_W'(size_i) <= CMP_W'(free_q));

  a_r3_release_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |=> alloc_q[$past(ch_i)] == '0);
endmodule

// File: rtl/tpa_seq.sv
module tpa_seq
  import tpa_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int CH_IN_W = 6,
  parameter int IDX_W   = 5,
  parameter int SIZE_W  = 7,
  parameter int CNT_W   = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [CH_IN_W-1:0] req_ch_i,
  input  logic               req_size_valid_i,
  input  logic [SIZE_W-1:0]  req_size_i,
  input  logic               req_abort_i,
  input  logic [CNT_W-1:0]   free_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               ok_o,
  output logic               irq_o,
  output logic [IDX_W-1:0]   ch_o,
  output logic [SIZE_W-1:0]  size_o,
  output logic               release_o,
  output logic               commit_o
);
  localparam int CMP_W = (SIZE_W > CNT_W) ? SIZE_W : CNT_W;

  tpa_state_e        state_q, state_d;
  logic [CH_IN_W-1:0] ch_q;
  logic [SIZE_W-1:0]  size_q;
  logic               resize_q, ch_ok_q;
  logic               done_q, ok_q, irq_q;
  logic               accept, fits;

  assign accept = req_valid_i && (state_q == ST_IDLE);
  assign fits   = CMP_W'(size_q) <= CMP_W'(free_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_CHECK;
      ST_CHECK: begin
        if (!ch_ok_q)              state_d = ST_FAIL;
        else if (!resize_q || fits) state_d = ST_COMMIT;
        else                        state_d = ST_FAIL;
      end
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ch_q     <= '0;
      size_q   <= '0;
      resize_q <= 1'b0;
      ch_ok_q  <= 1'b0;
      done_q   <= 1'b0;
      ok_q     <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        ch_q     <= req_ch_i;
        size_q   <= req_size_i;
        resize_q <= req_size_valid_i && !req_abort_i;
        ch_ok_q  <= req_ch_i < CH_IN_W'(NUM_CH);
      end
      done_q <= (state_q == ST_COMMIT) || (state_q == ST_FAIL);
      ok_q   <= (state_q == ST_COMMIT);
      irq_q  <= (state_q == ST_FAIL);
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign ok_o      = ok_q;
  assign irq_o     = irq_q;
  assign ch_o      = ch_q[IDX_W-1:0];
  assign size_o    = size_q;
  assign release_o = (state_q == ST_RELEASE) && resize_q && ch_ok_q;
  assign commit_o  = (state_q == ST_COMMIT) && resize_q;

  a_r4_irq_on_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o && !ok_o);

  a_r9_done_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/tx_pool_alloc.sv
module tx_pool_alloc #(
  parameter int NUM_CH     = 32,
  parameter int POOL_UNITS = 64,
  parameter int SIZE_W     = 7,
  localparam int IDX_W     = $clog2(NUM_CH),
  localparam int CH_IN_W   = IDX_W + 1,
  localparam int CNT_W     = $clog2(POOL_UNITS + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [CH_IN_W-1:0]       req_ch_i,
  input  logic                     req_size_valid_i,
  input  logic [SIZE_W-1:0]        req_size_i,
  input  logic                     req_abort_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     ok_o,
  output logic                     arf_irq_o,
  output logic [CNT_W-1:0]         free_cnt_o,
  output logic [NUM_CH*SIZE_W-1:0] alloc_flat_o
);
  logic [IDX_W-1:0]  ch;
  logic [SIZE_W-1:0] size;
  logic              rel, com;

  tpa_seq #(
    .NUM_CH (NUM_CH),
    .CH_IN_W(CH_IN_W),
    .IDX_W  (IDX_W),
    .SIZE_W (SIZE_W),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_ch_i        (req_ch_i),
    .req_size_valid_i(req_size_valid_i),
    .req_size_i      (req_size_i),
    .req_abort_i     (req_abort_i),
    .free_i          (free_cnt_o),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .ok_o            (ok_o),
    .irq_o           (arf_irq_o),
    .ch_o            (ch),
    .size_o          (size),
    .release_o       (rel),
    .commit_o        (com)
  );

  tpa_ledger #(
    .NUM_CH    (NUM_CH),
    .POOL_UNITS(POOL_UNITS),
    .SIZE_W    (SIZE_W),
    .CNT_W     (CNT_W),
    .IDX_W     (IDX_W)
  ) u_ledger (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ch_i        (ch),
    .size_i      (size),
    .release_i   (rel),
    .commit_i    (com),
    .free_o      (free_cnt_o),
    .alloc_flat_o(alloc_flat_o)
  );
endmodule

// File: tb/tx_pool_alloc_tb.sv
module tx_pool_alloc_tb;
  localparam int NUM_CH = 32;
  localparam int POOL   = 64;
  localparam int SW     = 7;
  localparam int CW     = 7;
  localparam int CHW    = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [CHW-1:0] req_ch_i = '0;
  logic req_size_valid_i = 1'b0;
  logic [SW-1:0] req_size_i = '0;
  logic req_abort_i = 1'b0;
  logic busy_o, done_o, ok_o, arf_irq_o;
  logic [CW-1:0] free_cnt_o;
  logic [NUM_CH*SW-1:0] alloc_flat_o;

  always #10 clk_i = ~clk_i;

  tx_pool_alloc u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ch_i(req_ch_i),
    .req_size_valid_i(req_size_valid_i), .req_size_i(req_size_i), .req_abort_i(req_abort_i),
    .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o), .arf_irq_o(arf_irq_o),
    .free_cnt_o(free_cnt_o), .alloc_flat_o(alloc_flat_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int exp_alloc [NUM_CH];
  int exp_free;

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int share(input int c);
    return int'(alloc_flat_o[c*SW +: SW]);
  endfunction

  // model: returns expected ok
  function automatic bit model(input int ch, input bit sv, input int sz, input bit ab);
    if (ch >= NUM_CH) return 1'b0;
    if (ab || !sv) return 1'b1;
    exp_free += exp_alloc[ch];
    exp_alloc[ch] = 0;
    if (sz <= exp_free) begin
      exp_alloc[ch] = sz;
      exp_free -= sz;
      return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic check_all(input string req);
    bit same = 1'b1;
    int bad = 0;
    for (int c = 0; c < NUM_CH; c++)
      if (share(c) != exp_alloc[c]) begin same = 1'b0; bad = c; end
    check(same, {req, " share table"}, share(bad), exp_alloc[bad]);
    check(int'(free_cnt_o) == exp_free, {req, " free count"}, int'(free_cnt_o), exp_free);
  endtask

  // Starts on a negedge, ends on the negedge where done_o is high.
  task automatic do_req(input int ch, input bit sv, input int sz, input bit ab, input string req);
    bit exp_ok;
    req_valid_i = 1'b1; req_ch_i = CHW'(ch); req_size_valid_i = sv;
    req_size_i = SW'(sz); req_abort_i = ab;
    exp_ok = model(ch, sv, sz, ab);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(busy_o && !done_o, "R9 busy after accept", int'(busy_o), 1);
    @(negedge clk_i);
    // stray strobe while busy: must be ignored (R9)
    req_valid_i = 1'b1; req_ch_i = CHW'((ch + 1) % NUM_CH); req_size_valid_i = 1'b1;
    req_size_i = SW'(1); req_abort_i = 1'b0;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(busy_o && !done_o, "R9 busy mid sequence", int'(busy_o), 1);
    @(negedge clk_i);
    check(done_o && !busy_o, {req, " R2 done after three edges"}, int'(done_o), 1);
    check(ok_o == exp_ok, {req, " ok"}, int'(ok_o), int'(exp_ok));
    check(arf_irq_o == !exp_ok, {req, " R4 irq"}, int'(arf_irq_o), int'(!exp_ok));
    check_all({req, " R5 R9"});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < NUM_CH; c++) exp_alloc[c] = 0;
    exp_free = POOL;
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !ok_o && !arf_irq_o, "R1 reset outputs", int'(busy_o), 0);
    check_all("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);

    do_req(0, 1, 40, 0, "R2 ch0=40");
    do_req(1, 1, 24, 0, "R2 ch1=24 pool full");
    do_req(0, 1, 50, 0, "R4 ch0 50 too big");
    check(share(0) == 0, "R4 failed channel holds nothing", share(0), 0);
    do_req(1, 1, 60, 0, "R3 ch1 reuses own share");
    check(share(1) == 60 && free_cnt_o == 4, "R3 release first", share(1), 60);
    do_req(1, 1, 0, 0, "R10 resize to zero");
    check(int'(free_cnt_o) == POOL, "R10 pool restored", int'(free_cnt_o), POOL);
    do_req(2, 1, 10, 0, "R2 ch2=10");
    do_req(2, 0, 0, 0, "R6 size not valid");
    check(share(2) == 10, "R6 share unchanged", share(2), 10);
    do_req(2, 1, 5, 1, "R7 abort with size");
    check(share(2) == 10, "R7 share untouched", share(2), 10);
    do_req(2, 0, 0, 1, "R7 abort plain");
    do_req(40, 1, 3, 0, "R8 channel out of range");
    do_req(NUM_CH, 1, 3, 0, "R8 channel equal NUM_CH");
    do_req(31, 1, 127, 0, "R4 size above pool");
    do_req(31, 1, 54, 0, "R2 exact fit");
    check(free_cnt_o == 0, "R2 exact fit leaves zero", int'(free_cnt_o), 0);

    for (int n = 0; n < 300; n++) begin
      int ch = int'($urandom_range(0, 35));
      bit sv = ($urandom_range(0, 9) < 8);
      bit ab = ($urandom_range(0, 9) == 0);
      int sz = sv ? int'($urandom_range(0, 40)) : 0;
      do_req(ch, sv, sz, ab, "R2 R3 R4 R6 R7 R8 random");
    end

    @(negedge clk_i);
    check(!done_o && !busy_o, "R2 done single cycle", int'(done_o), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule